// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside the two access ports of a shared dual-port memory and watches for the case where both ports are selected on the same word at once. When that happens, it picks one port to keep normal access. The other port is told it lost: its active-low busy flag goes low, and its write strobe toward the memory array is suppressed. Reads from the losing port are not affected. The block only qualifies the write strobes; the array itself lives elsewhere.

The losing port is the one whose select and address settled later. Settling is judged per clock cycle: a port counts as newly arrived in a cycle when its select or address differs from the value seen in the previous cycle. If both ports arrive in the same cycle, the left port wins. Once a loser is chosen, it is held for as long as the collision lasts. The choice is released when the addresses part or either port is deselected.

A mode input selects between two roles. As the master, the block arbitrates itself and drives the busy flags. As a slave, it drives both busy flags high and takes busy indications from outside instead; each of these can only block the writes of its own port.

Top module: `dp_collide_arb`

## Requirements
- R1: In master mode, both busy outputs are high (1) unless both selects are low (active-low, 0 = selected) and the two addresses are equal.
- R2: When one port is already selected and the other port becomes selected on the same address in a later cycle, the later port's busy output goes low and the earlier port's busy output stays high.
- R3: When both ports become selected on the same address in the same cycle, the right port's busy output goes low and the left stays high.
- R4: The two busy outputs are never low in the same cycle.
- R5: While a port's busy output is low, its memory write strobe (active-low) is held high, whatever that port's write input does.
- R6: The busy port stays the same in every cycle that the collision continues. Both busy outputs return high in the first cycle in which the addresses differ or either select is high.
- R7: In slave mode, both busy outputs are high. A low external busy input forces that port's memory write strobe high, and a high one lets the strobe through. In master mode, the external busy inputs have no effect.
- R8: A port's memory write strobe is low exactly when that port's select and write inputs are both low and the port is not blocked under R5 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = master (arbitrate), 0 = slave |
| cs_l_n | input | 1 | Left port select, active low |
| addr_l | input | AW | Left port word address |
| we_l_n | input | 1 | Left port write strobe, active low |
| cs_r_n | input | 1 | Right port select, active low |
| addr_r | input | AW | Right port word address |
| we_r_n | input | 1 | Right port write strobe, active low |
| busy_l_in_n | input | 1 | External busy for left port (slave mode), active low |
| busy_r_in_n | input | 1 | External busy for right port (slave mode), active low |
| busy_l_n | output | 1 | Left port lost arbitration, active low |
| busy_r_n | output | 1 | Right port lost arbitration, active low |
| ram_we_l_n | output | 1 | Qualified left write strobe to array, active low |
| ram_we_r_n | output | 1 | Qualified right write strobe to array, active low |

## Verification
The hardest situation to reach is a collision whose arrival order is decided by history rather than by the present inputs. The same pair of addresses must give opposite busy outputs depending on which port settled first. The stimulus therefore parks both ports idle for a cycle, then opens one port and, a cycle later, the other. Each order is swept over every pair of addresses in a three-bit configuration. A same-cycle opening after the idle cycle reaches the tie. Holding the colliding inputs for an extra cycle shows the choice is retained, and moving one address shows it is released.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  typedef enum logic { SIDE_L = 1'b0, SIDE_R = 1'b1 } side_e;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/dpca_track.sv
module dpca_track #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  output logic          fresh
);
  logic          cs_q, cs_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          smp_en;

  assign smp_en = 1'b1;

  always_comb begin
    cs_d   = cs_q;
    addr_d = addr_q;
    if (smp_en) begin
      cs_d   = cs_n;
      addr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      cs_q   <= cs_d;
      addr_q <= addr_d;
    end
  end

  assign fresh = (cs_n != cs_q) || (addr != addr_q);
endmodule

// File: rtl/dpca_order.sv
module dpca_order (
  input  logic clk,
  input  logic rst_n,
  input  logic coll,
  input  logic fresh_l,
  input  logic fresh_r,
  output logic lose_l,
  output logic lose_r
);
  logic held_q, held_d;
  logic hl_q, hl_d;
  logic now_l;

  // left loses only when it alone moved this cycle; ties go to left
  assign now_l  = fresh_l && !fresh_r;
  assign lose_l = held_q ? hl_q : now_l;
  assign lose_r = !lose_l;

  always_comb begin
    held_d = held_q;
    hl_d   = hl_q;
    if (coll) begin
      held_d = 1'b1;
      hl_d   = lose_l;
    end else begin
      held_d = 1'b0;
      hl_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      hl_q   <= 1'b0;
    end else begin
      held_q <= held_d;
      hl_q   <= hl_d;
    end
  end
endmodule

// File: rtl/dpca_wgate.sv
module dpca_wgate (
  input  logic master,
  input  logic cs_n,
  input  logic we_n,
  input  logic busy_int_n,
  input  logic busy_ext_n,
  output logic busy_o_n,
  output logic ram_we_n
);
  logic blk;

  assign blk      = master ? !busy_int_n : !busy_ext_n;
  assign busy_o_n = master ? busy_int_n : 1'b1;
  assign ram_we_n = cs_n || we_n || blk;
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_i,
  input  logic          cs_l_n,
  input  logic [AW-1:0] addr_l,
  input  logic          we_l_n,
  input  logic          cs_r_n,
  input  logic [AW-1:0] addr_r,
  input  logic          we_r_n,
  input  logic          busy_l_in_n,
  input  logic          busy_r_in_n,
  output logic          busy_l_n,
  output logic          busy_r_n,
  output logic          ram_we_l_n,
  output logic          ram_we_r_n
);
  import dpca_pkg::*;

  logic          cs_v    [NUM_SIDES];
  logic [AW-1:0] addr_v  [NUM_SIDES];
  logic          we_v    [NUM_SIDES];
  logic          bext_v  [NUM_SIDES];
  logic          fresh_v [NUM_SIDES];
  logic          lose_v  [NUM_SIDES];
  logic          bint_v  [NUM_SIDES];
  logic          bout_v  [NUM_SIDES];
  logic          rwe_v   [NUM_SIDES];
  logic          coll;

  assign cs_v[SIDE_L]   = cs_l_n;
  assign cs_v[SIDE_R]   = cs_r_n;
  assign addr_v[SIDE_L] = addr_l;
  assign addr_v[SIDE_R] = addr_r;
  assign we_v[SIDE_L]   = we_l_n;
  assign we_v[SIDE_R]   = we_r_n;
  assign bext_v[SIDE_L] = busy_l_in_n;
  assign bext_v[SIDE_R] = busy_r_in_n;

  assign coll = !cs_l_n && !cs_r_n && (addr_l == addr_r);

  dpca_order u_order (
    .clk    (clk),
    .rst_n  (rst_n),
    .coll   (coll),
    .fresh_l(fresh_v[SIDE_L]),
    .fresh_r(fresh_v[SIDE_R]),
    .lose_l (lose_v[SIDE_L]),
    .lose_r (lose_v[SIDE_R])
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dpca_track #(.AW(AW)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .cs_n (cs_v[s]),
      .addr (addr_v[s]),
      .fresh(fresh_v[s])
    );

    assign bint_v[s] = !(coll && lose_v[s]);

    dpca_wgate u_wgate (
      .master    (master_i),
      .cs_n      (cs_v[s]),
      .we_n      (we_v[s]),
      .busy_int_n(bint_v[s]),
      .busy_ext_n(bext_v[s]),
      .busy_o_n  (bout_v[s]),
      .ram_we_n  (rwe_v[s])
    );
  end

  assign busy_l_n   = bout_v[SIDE_L];
  assign busy_r_n   = bout_v[SIDE_R];
  assign ram_we_l_n = rwe_v[SIDE_L];
  assign ram_we_r_n = rwe_v[SIDE_R];
endmodule

// File: rtl/dpca_chk.sv
module dpca_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_i,
  input logic          cs_l_n,
  input logic [AW-1:0] addr_l,
  input logic          we_l_n,
  input logic          cs_r_n,
  input logic [AW-1:0] addr_r,
  input logic          we_r_n,
  input logic          busy_l_in_n,
  input logic          busy_r_in_n,
  input logic          busy_l_n,
  input logic          busy_r_n,
  input logic          ram_we_l_n,
  input logic          ram_we_r_n
);
  logic hit;
  assign hit = !cs_l_n && !cs_r_n && (addr_l == addr_r);

  // R1
  idle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (busy_l_n && busy_r_n));

  // R4
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!busy_l_n && !busy_r_n));

  // R5
  loser_l_wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_l_n |-> ram_we_l_n);

  // R5
  loser_r_wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_r_n |-> ram_we_r_n);

  // R6
  hold_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $past(master_i) && hit && $past(hit) && $past(!busy_r_n)) |-> !busy_r_n);

  // R6
  hold_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $past(master_i) && hit && $past(hit) && $past(!busy_l_n)) |-> !busy_l_n);

  // R7
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |-> (busy_l_n && busy_r_n));

  // R7
  slave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && (!busy_l_in_n || !busy_r_in_n)) |->
      ((busy_l_in_n || ram_we_l_n) && (busy_r_in_n || ram_we_r_n)));

  // R8
  idle_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_l_n || we_l_n) |-> ram_we_l_n);
endmodule

bind dp_collide_arb dpca_chk #(.AW(AW)) u_chk (.*);

// File: tb/dp_collide_arb_bench.sv
module dp_collide_arb_bench;
  localparam int AW = 3;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          master_i;
  logic          cs_l_n, cs_r_n, we_l_n, we_r_n;
  logic [AW-1:0] addr_l, addr_r;
  logic          busy_l_in_n, busy_r_in_n;
  logic          busy_l_n, busy_r_n, ram_we_l_n, ram_we_r_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dp_collide_arb #(.AW(AW)) u_dp_collide_arb (
    .clk(clk), .rst_n(rst_n), .master_i(master_i),
    .cs_l_n(cs_l_n), .addr_l(addr_l), .we_l_n(we_l_n),
    .cs_r_n(cs_r_n), .addr_r(addr_r), .we_r_n(we_r_n),
    .busy_l_in_n(busy_l_in_n), .busy_r_in_n(busy_r_in_n),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .ram_we_l_n(ram_we_l_n), .ram_we_r_n(ram_we_r_n)
  );

  // R4 on every cycle
  always @(posedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      total++;
      if (busy_l_n === 1'b0 && busy_r_n === 1'b0) begin
        bad++;
        $display("FAIL R4: both busy low act=%b%b exp=not 00", busy_l_n, busy_r_n);
      end
    end
  end

  task automatic apply(input logic m, input logic cl, input logic [AW-1:0] al,
                       input logic wl, input logic cr, input logic [AW-1:0] ar,
                       input logic wr, input logic bl, input logic br);
    @(negedge clk);
    #1;
    master_i = m; cs_l_n = cl; addr_l = al; we_l_n = wl;
    cs_r_n = cr; addr_r = ar; we_r_n = wr;
    busy_l_in_n = bl; busy_r_in_n = br;
    #3;
  endtask

  // bits: {busy_l_n, busy_r_n, ram_we_l_n, ram_we_r_n}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {busy_l_n, busy_r_n, ram_we_l_n, ram_we_r_n};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    #3_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    master_i = 1'b1; cs_l_n = 1'b1; cs_r_n = 1'b1; we_l_n = 1'b1; we_r_n = 1'b1;
    addr_l = '0; addr_r = '0; busy_l_in_n = 1'b1; busy_r_in_n = 1'b1;
    repeat (3) @(posedge clk);
    #4;
    chk("R1 reset", 4'b1111);
    @(negedge clk);
    rst_n = 1'b1;

    // left first, right later; external busy inputs low to show master ignores them (R7)
    for (int al = 0; al < NA; al++) begin
      for (int ar = 0; ar < NA; ar++) begin
        apply(1, 1, AW'(al), 1, 1, AW'(ar), 1, 0, 0);
        chk("R1 idle", 4'b1111);
        apply(1, 0, AW'(al), 0, 1, AW'(ar), 0, 0, 0);
        chk("R8 left alone writes", 4'b1101);
        apply(1, 0, AW'(al), 0, 0, AW'(ar), 0, 0, 0);
        if (al == ar) chk("R2 R5 R7 right later loses", 4'b1001);
        else          chk("R1 R8 no match", 4'b1100);
        apply(1, 0, AW'(al), 0, 0, AW'(ar), 0, 0, 0);
        if (al == ar) chk("R6 hold right busy", 4'b1001);
        else          chk("R1 hold no match", 4'b1100);
        if (al == ar) begin
          apply(1, 0, AW'(al), 0, 0, AW'(ar ^ 1), 0, 0, 0);
          chk("R6 clear on addr change", 4'b1100);
        end
      end
    end

    // right first, left later
    for (int al = 0; al < NA; al++) begin
      for (int ar = 0; ar < NA; ar++) begin
        apply(1, 1, AW'(al), 1, 1, AW'(ar), 1, 1, 1);
        chk("R1 idle", 4'b1111);
        apply(1, 1, AW'(al), 0, 0, AW'(ar), 0, 1, 1);
        chk("R8 right alone writes", 4'b1110);
        apply(1, 0, AW'(al), 0, 0, AW'(ar), 0, 1, 1);
        if (al == ar) chk("R2 R5 left later loses", 4'b0110);
        else          chk("R1 R8 no match", 4'b1100);
        apply(1, 0, AW'(al), 0, 0, AW'(ar), 0, 1, 1);
        if (al == ar) chk("R6 hold left busy", 4'b0110);
        else          chk("R1 hold no match", 4'b1100);
        apply(1, 0, AW'(al), 1, 0, AW'(ar), 0, 1, 1);
        if (al == ar) chk("R5 R6 left read only", 4'b0110);
        else          chk("R8 left read", 4'b1110);
        if (al == ar) begin
          apply(1, 0, AW'(al), 0, 1, AW'(ar), 0, 1, 1);
          chk("R6 clear on deselect", 4'b1101);
        end
      end
    end

    // same-cycle arrival: left wins
    for (int a = 0; a < NA; a++) begin
      apply(1, 1, AW'(a), 1, 1, AW'(a), 1, 1, 1);
      chk("R1 idle", 4'b1111);
      apply(1, 0, AW'(a), 0, 0, AW'(a), 0, 1, 1);
      chk("R3 tie right loses", 4'b1001);
      apply(1, 0, AW'(a), 0, 0, AW'(a), 0, 1, 1);
      chk("R3 R6 tie held", 4'b1001);
    end

    // slave mode: busy inputs gate writes, outputs stay high
    for (int m = 0; m < 4; m++) begin
      logic bl, br;
      bl = m[0];
      br = m[1];
      apply(0, 1, 3'd2, 1, 1, 3'd2, 1, 1, 1);
      chk("R7 slave idle", 4'b1111);
      apply(0, 0, 3'd2, 0, 0, 3'd2, 0, bl, br);
      chk("R7 slave gate", {1'b1, 1'b1, ~bl, ~br});
      apply(0, 0, 3'd2, 1, 0, 3'd5, 1, bl, br);
      chk("R7 R8 slave no write", 4'b1111);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule